// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Condition-Code Register

This block is the datapath core of a small 8-bit processor. It takes two 8-bit operands and a 5-bit operation code, and it computes the result combinationally. The current condition flags come from a six-bit condition-code register held inside the block. Each operation has its own rule for each flag: some flags are computed, some are forced and some are kept. A decimal-adjust operation corrects a packed BCD sum using the half-carry and carry flags.

The block computes the next flag value every cycle. The register takes it on the next rising clock edge only when `flag_we` is high. `res_wr` tells the surrounding datapath whether the operation writes its result back. Compare, bit test and test do not write back. On those operations and on unused codes, `result` simply shows operand A.

Operation codes on `op_sel` (decimal):

| Code | Name | Code | Name |
|------|------|------|------|
| 0 | ADD | 12 | DEC |
| 1 | ADC | 13 | TST |
| 2 | SUB | 14 | CLR |
| 3 | SBC | 15 | ASL |
| 4 | CMP | 16 | ASR |
| 5 | AND | 17 | LSR |
| 6 | OR | 18 | ROL |
| 7 | XOR | 19 | ROR |
| 8 | BIT | 20 | DAA |
| 9 | NEG | 21 | PASS (result = B) |
| 10 | COM | 22 | SETF (load flags from A) |
| 11 | INC | 23–31 | unused |

The block has no state machine. Its only state is the flag register, which has two conditions: it loads when `flag_we` is high and holds when it is low.

Top module: `alu8_flags`

## Requirements
- R1: `ccr_q` packs C in bit 0, V in bit 1, Z in bit 2, N in bit 3, I in bit 4 and H in bit 5. Bits 7:6 always read 1. Reset gives 0xD0. No operation other than SETF changes I.
- R2: The flag register loads the computed flags on a rising edge only while `flag_we` is 1. Otherwise it holds its value.
- R3: ADD (0) and ADC (1) produce A+B, or A+B+C for ADC. H is the carry out of bit 3 including the carry-in. C is bit 8 of the 9-bit sum. V is the signed overflow of that sum.
- R4: SUB (2), SBC (3) and CMP (4) compute A−B, or A−B−C for SBC and A−B for CMP. C is the borrow and V is the signed overflow. CMP sets the flags exactly as SUB does, but `res_wr`=0 and `result`=A. H is kept.
- R5: AND (5), OR (6), XOR (7), BIT (8) and PASS (21) clear V and keep C and H. BIT uses A AND B for its flags, with `res_wr`=0 and `result`=A.
- R6: NEG (9) gives 0−A, with V=1 only for a 0x80 result and C=1 for any nonzero result. COM (10) gives ~A with V=0 and C=1. TST (13) clears V and C, with `res_wr`=0. CLR (14) gives 0 with N, V and C cleared.
- R7: INC (11) and DEC (12) add or subtract 1 and leave C unchanged. V=1 only for an INC of 0x7F or a DEC of 0x80.
- R8: ASL (15), ASR (16), LSR (17), ROL (18) and ROR (19) set C to the bit shifted out. ASL and LSR fill the vacated bit with 0. ASR repeats bit 7. The rotates fill the vacated bit with the old C. For all five, V = N XOR C of the new value, and LSR always gives N=0.
- R9: DAA (20) adds 0x06 when H=1 or A[3:0]>9. It adds 0x60 when C=1, A[7:4]>9, or A[7:4]>8 with A[3:0]>9. When both hold it adds 0x66. C is the carry out of that addition and V is kept.
- R10: SETF (22) loads flag bits 5:0 from A[5:0], with `res_wr`=0.
- R11: Unused codes 23–31 keep all flags, give `res_wr`=0 and `result`=A.
- R12: For every operation from 0 to 21, N is bit 7 and Z is the zero test of the computed value: the difference for CMP, A AND B for BIT, and A for TST.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | Operand A (accumulator side) |
| opnd_b | input | 8 | Operand B |
| flag_we | input | 1 | Flag register write enable |
| result | output | 8 | Operation result, or A when no write-back |
| res_wr | output | 1 | Result should be written back |
| ccr_q | output | 8 | Condition-code register contents |

## Verification
Each operation is tried with operands that sit on its flag boundaries:
- signed overflow against a plain carry;
- a nibble carry with and without a carry-in;
- a borrow when the result is zero;
- 0x7F, 0x80 and 0xFF for increment, decrement and negate.

Each case starts from a preset flag value, so a flag that should be kept is told apart from one that should be recomputed. The decimal-adjust cases separate low-only, high-only and combined corrections. Directed tests hold the flags with the write enable low, exercise reset, and confirm that unused codes change nothing.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NW  = 4;
    localparam int CCW = 6;
    localparam int OPW = 5;
    localparam logic [DW-1:0] CCR_RST = 8'hD0;

    localparam int CC_C = 0;
    localparam int CC_V = 1;
    localparam int CC_Z = 2;
    localparam int CC_N = 3;
    localparam int CC_I = 4;
    localparam int CC_H = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_CMP  = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
        OP_BIT  = 5'd8,  OP_NEG = 5'd9,  OP_COM = 5'd10, OP_INC = 5'd11,
        OP_DEC  = 5'd12, OP_TST = 5'd13, OP_CLR = 5'd14, OP_ASL = 5'd15,
        OP_ASR  = 5'd16, OP_LSR = 5'd17, OP_ROL = 5'd18, OP_ROR = 5'd19,
        OP_DAA  = 5'd20, OP_PASS = 5'd21, OP_SETF = 5'd22
    } alu_op_e;

    typedef struct packed {
        logic          hit;
        logic [DW-1:0] val;
        logic          h;
        logic          c;
        logic          v;
    } unit_out_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          h_i,
    input  logic          c_i,
    input  logic          v_i,
    output unit_out_t     o
);
    localparam int EW = DW + 1;
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

    logic [EW-1:0] s;
    logic          cx;

    always_comb begin
        o     = '0;
        o.h   = h_i;
        o.c   = c_i;
        o.v   = v_i;
        s     = '0;
        cx    = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                cx    = (op == OP_ADC) ? c_i : 1'b0;
                s     = EW'(a) + EW'(b) + EW'(cx);
                o.hit = 1'b1;
                o.val = s[DW-1:0];
                o.h   = a[NW] ^ b[NW] ^ s[NW];
                o.c   = s[DW];
                o.v   = (a[DW-1] == b[DW-1]) && (s[DW-1] != a[DW-1]);
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                cx    = (op == OP_SBC) ? c_i : 1'b0;
                s     = EW'(a) - EW'(b) - EW'(cx);
                o.hit = 1'b1;
                o.val = s[DW-1:0];
                o.c   = s[DW];
                o.v   = (a[DW-1] != b[DW-1]) && (s[DW-1] != a[DW-1]);
            end
            OP_NEG: begin
                s     = EW'(0) - EW'(a);
                o.hit = 1'b1;
                o.val = s[DW-1:0];
                o.v   = (s[DW-1:0] == SMIN);
                o.c   = |s[DW-1:0];
            end
            OP_INC: begin
                o.hit = 1'b1;
                o.val = a + DW'(1);
                o.v   = (a == SMAX);
            end
            OP_DEC: begin
                o.hit = 1'b1;
                o.val = a - DW'(1);
                o.v   = (a == SMIN);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_logic_shift.sv
module alu8_logic_shift
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          h_i,
    input  logic          c_i,
    input  logic          v_i,
    output unit_out_t     o
);
    always_comb begin
        o     = '0;
        o.h   = h_i;
        o.c   = c_i;
        o.v   = v_i;
        o.hit = 1'b1;
        case (op)
            OP_AND, OP_BIT: begin o.val = a & b; o.v = 1'b0; end
            OP_OR:          begin o.val = a | b; o.v = 1'b0; end
            OP_XOR:         begin o.val = a ^ b; o.v = 1'b0; end
            OP_PASS:        begin o.val = b;     o.v = 1'b0; end
            OP_COM:         begin o.val = ~a; o.v = 1'b0; o.c = 1'b1; end
            OP_TST:         begin o.val = a;  o.v = 1'b0; o.c = 1'b0; end
            OP_CLR:         begin o.val = '0; o.v = 1'b0; o.c = 1'b0; end
            OP_ASL: begin
                o.c   = a[DW-1];
                o.val = {a[DW-2:0], 1'b0};
                o.v   = o.val[DW-1] ^ o.c;
            end
            OP_ASR: begin
                o.c   = a[0];
                o.val = {a[DW-1], a[DW-1:1]};
                o.v   = o.val[DW-1] ^ o.c;
            end
            OP_LSR: begin
                o.c   = a[0];
                o.val = {1'b0, a[DW-1:1]};
                o.v   = o.c;
            end
            OP_ROL: begin
                o.c   = a[DW-1];
                o.val = {a[DW-2:0], c_i};
                o.v   = o.val[DW-1] ^ o.c;
            end
            OP_ROR: begin
                o.c   = a[0];
                o.val = {c_i, a[DW-1:1]};
                o.v   = o.val[DW-1] ^ o.c;
            end
            default: o.hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_bcd_adjust.sv
module alu8_bcd_adjust
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic          h_i,
    input  logic          c_i,
    input  logic          v_i,
    output unit_out_t     o
);
    localparam int EW = DW + 1;
    localparam logic [NW-1:0] SIX = NW'(6);

    logic [NW-1:0] lo, hi;
    logic          lo_fix, hi_fix;
    logic [DW-1:0] corr;
    logic [EW-1:0] s;

    always_comb begin
        lo     = a[NW-1:0];
        hi     = a[DW-1:NW];
        lo_fix = h_i || (lo > NW'(9));
        hi_fix = c_i || (hi > NW'(9)) || ((hi > NW'(8)) && (lo > NW'(9)));
        corr   = {(hi_fix ? SIX : '0), (lo_fix ? SIX : '0)};
        s      = EW'(a) + EW'(corr);
        o      = '0;
        o.hit  = (op == OP_DAA);
        o.val  = s[DW-1:0];
        o.h    = h_i;
        o.c    = s[DW];
        o.v    = v_i;
    end
endmodule

// File: rtl/alu8_ccr.sv
module alu8_ccr
    import alu8_pkg::*;
#(
    parameter logic [DW-1:0] RST_VAL = CCR_RST
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [CCW-1:0] d,
    output logic [DW-1:0]  q
);
    logic [CCW-1:0] r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  r <= RST_VAL[CCW-1:0];
        else if (we) r <= d;
    end

    assign q = {{(DW-CCW){1'b1}}, r};
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0]  opnd_a,
    input  logic [DW-1:0]  opnd_b,
    input  logic           flag_we,
    output logic [DW-1:0]  result,
    output logic           res_wr,
    output logic [DW-1:0]  ccr_q
);
    alu_op_e        op;
    logic [CCW-1:0] cc;
    logic [CCW-1:0] flags_nx;
    unit_out_t      u_as, u_ls, u_bcd, sel;

    assign op = alu_op_e'(op_sel);
    assign cc = ccr_q[CCW-1:0];

    alu8_addsub u_addsub (
        .op(op), .a(opnd_a), .b(opnd_b),
        .h_i(cc[CC_H]), .c_i(cc[CC_C]), .v_i(cc[CC_V]), .o(u_as)
    );

    alu8_logic_shift u_lsh (
        .op(op), .a(opnd_a), .b(opnd_b),
        .h_i(cc[CC_H]), .c_i(cc[CC_C]), .v_i(cc[CC_V]), .o(u_ls)
    );

    alu8_bcd_adjust u_bcd_adj (
        .op(op), .a(opnd_a),
        .h_i(cc[CC_H]), .c_i(cc[CC_C]), .v_i(cc[CC_V]), .o(u_bcd)
    );

    always_comb begin
        if (u_as.hit)       sel = u_as;
        else if (u_ls.hit)  sel = u_ls;
        else if (u_bcd.hit) sel = u_bcd;
        else                sel = '0;
    end

    always_comb begin
        flags_nx = cc;
        if (op == OP_SETF) begin
            flags_nx = opnd_a[CCW-1:0];
        end else if (sel.hit) begin
            flags_nx[CC_H] = sel.h;
            flags_nx[CC_N] = sel.val[DW-1];
            flags_nx[CC_Z] = (sel.val == '0);
            flags_nx[CC_V] = sel.v;
            flags_nx[CC_C] = sel.c;
        end
    end

    always_comb begin
        res_wr = sel.hit && !(op inside {OP_CMP, OP_BIT, OP_TST});
        result = res_wr ? sel.val : opnd_a;
    end

    alu8_ccr u_ccr (
        .clk(clk), .rst_n(rst_n), .we(flag_we), .d(flags_nx), .q(ccr_q)
    );
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
    import alu8_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] op_sel,
    input logic [DW-1:0]  opnd_a,
    input logic           flag_we,
    input logic [DW-1:0]  result,
    input logic           res_wr,
    input logic [DW-1:0]  ccr_q,
    input logic [CCW-1:0] flags_nx
);
    p_fixed_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_q[DW-1:CCW] == '1);

    p_imask_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel != OP_SETF) |=> ccr_q[CC_I] == $past(ccr_q[CC_I]));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(ccr_q));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> ccr_q[CCW-1:0] == $past(flags_nx));

    p_cmp_nowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CMP) |-> (!res_wr && result == opnd_a));

    p_incdec_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_INC || op_sel == OP_DEC) |-> flags_nx[CC_C] == ccr_q[CC_C]);

    p_lsr_nonneg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_LSR) |-> !flags_nx[CC_N]);

    p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > OP_SETF) |-> (flags_nx == ccr_q[CCW-1:0] && !res_wr && result == opnd_a));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
    .flag_we(flag_we), .result(result), .res_wr(res_wr),
    .ccr_q(ccr_q), .flags_nx(flags_nx)
);

// File: tb/alu8_flags_bench.sv
`timescale 1ns/100ps
module alu8_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic       flag_we = 1'b0;
    logic [7:0] result;
    logic       res_wr;
    logic [7:0] ccr_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_flags u_alu8_flags (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .flag_we(flag_we), .result(result),
        .res_wr(res_wr), .ccr_q(ccr_q)
    );

    // {op[4:0], a[7:0], b[7:0], preset flags[5:0], result[7:0], wr, ccr[7:0]}
    localparam logic [43:0] VEC [39] = '{
        {5'd0,  8'h08, 8'h08, 6'h00, 8'h10, 1'b1, 8'hE0},
        {5'd0,  8'h7F, 8'h01, 6'h00, 8'h80, 1'b1, 8'hEA},
        {5'd0,  8'hFF, 8'h01, 6'h10, 8'h00, 1'b1, 8'hF5},
        {5'd1,  8'h0F, 8'h00, 6'h01, 8'h10, 1'b1, 8'hE0},
        {5'd1,  8'hFF, 8'h00, 6'h01, 8'h00, 1'b1, 8'hE5},
        {5'd1,  8'h7F, 8'h00, 6'h01, 8'h80, 1'b1, 8'hEA},
        {5'd2,  8'h00, 8'h01, 6'h00, 8'hFF, 1'b1, 8'hC9},
        {5'd2,  8'h80, 8'h01, 6'h20, 8'h7F, 1'b1, 8'hE2},
        {5'd3,  8'h05, 8'h05, 6'h01, 8'hFF, 1'b1, 8'hC9},
        {5'd3,  8'h10, 8'h0F, 6'h01, 8'h00, 1'b1, 8'hC4},
        {5'd4,  8'h40, 8'h40, 6'h03, 8'h40, 1'b0, 8'hC4},
        {5'd4,  8'h10, 8'h20, 6'h00, 8'h10, 1'b0, 8'hC9},
        {5'd5,  8'hF0, 8'h3C, 6'h23, 8'h30, 1'b1, 8'hE1},
        {5'd6,  8'h80, 8'h01, 6'h02, 8'h81, 1'b1, 8'hC8},
        {5'd7,  8'h5A, 8'h5A, 6'h01, 8'h00, 1'b1, 8'hC5},
        {5'd8,  8'h0F, 8'hF0, 6'h02, 8'h0F, 1'b0, 8'hC4},
        {5'd9,  8'h80, 8'h00, 6'h00, 8'h80, 1'b1, 8'hCB},
        {5'd9,  8'h00, 8'h00, 6'h01, 8'h00, 1'b1, 8'hC4},
        {5'd10, 8'h00, 8'h00, 6'h02, 8'hFF, 1'b1, 8'hC9},
        {5'd11, 8'h7F, 8'h00, 6'h01, 8'h80, 1'b1, 8'hCB},
        {5'd11, 8'hFF, 8'h00, 6'h00, 8'h00, 1'b1, 8'hC4},
        {5'd12, 8'h80, 8'h00, 6'h00, 8'h7F, 1'b1, 8'hC2},
        {5'd12, 8'h01, 8'h00, 6'h03, 8'h00, 1'b1, 8'hC5},
        {5'd13, 8'h80, 8'h00, 6'h03, 8'h80, 1'b0, 8'hC8},
        {5'd14, 8'h55, 8'h00, 6'h0B, 8'h00, 1'b1, 8'hC4},
        {5'd15, 8'h81, 8'h00, 6'h00, 8'h02, 1'b1, 8'hC3},
        {5'd15, 8'h40, 8'h00, 6'h00, 8'h80, 1'b1, 8'hCA},
        {5'd16, 8'h81, 8'h00, 6'h00, 8'hC0, 1'b1, 8'hC9},
        {5'd17, 8'h01, 8'h00, 6'h08, 8'h00, 1'b1, 8'hC7},
        {5'd18, 8'h80, 8'h00, 6'h01, 8'h01, 1'b1, 8'hC3},
        {5'd19, 8'h01, 8'h00, 6'h01, 8'h80, 1'b1, 8'hC9},
        {5'd19, 8'h02, 8'h00, 6'h00, 8'h01, 1'b1, 8'hC0},
        {5'd20, 8'h0A, 8'h00, 6'h00, 8'h10, 1'b1, 8'hC0},
        {5'd20, 8'h9A, 8'h00, 6'h00, 8'h00, 1'b1, 8'hC5},
        {5'd20, 8'h12, 8'h00, 6'h20, 8'h18, 1'b1, 8'hE0},
        {5'd20, 8'h73, 8'h00, 6'h01, 8'hD3, 1'b1, 8'hC8},
        {5'd21, 8'h11, 8'h00, 6'h03, 8'h00, 1'b1, 8'hC5},
        {5'd31, 8'h5A, 8'h00, 6'h2B, 8'h5A, 1'b0, 8'hEB},
        {5'd22, 8'h3F, 8'h00, 6'h00, 8'h3F, 1'b0, 8'hFF}
    };

    function automatic string req_of(input logic [4:0] op);
        if (op <= 5'd1)       return "R3";
        else if (op <= 5'd4)  return "R4";
        else if (op <= 5'd8 || op == 5'd21) return "R5";
        else if (op == 5'd11 || op == 5'd12) return "R7";
        else if (op <= 5'd14) return "R6";
        else if (op <= 5'd19) return "R8";
        else if (op == 5'd20) return "R9";
        else if (op == 5'd22) return "R10";
        else                  return "R11";
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic we);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; flag_we = we;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset value", ccr_q, 8'hD0);
        rst_n = 1'b1;

        for (int i = 0; i < 39; i++) begin
            logic [43:0] v;
            string tag;
            v   = VEC[i];
            tag = req_of(v[43:39]);
            apply(5'd22, {2'b00, v[22:17]}, 8'h00, 1'b1);
            apply(v[43:39], v[38:31], v[30:23], 1'b1);
            #1;
            chk({tag, " result"}, result, v[16:9]);
            chk({tag, " write-back"}, {7'd0, res_wr}, {7'd0, v[8]});
            @(posedge clk);
            #1;
            chk({tag, " flags"}, ccr_q, v[7:0]);
            chk("R12 N/Z", {4'd0, ccr_q[3:2], 2'd0}, {4'd0, v[3:2], 2'd0});
        end

        // R2: write enable low holds flags despite a flag-changing operation
        apply(5'd22, 8'h00, 8'h00, 1'b1);
        apply(5'd0, 8'hFF, 8'h01, 1'b0);
        @(posedge clk);
        #1;
        chk("R2 hold with enable low", ccr_q, 8'hC0);

        // R1: I bit not touched by a flag-writing arithmetic operation
        apply(5'd22, 8'h10, 8'h00, 1'b1);
        apply(5'd14, 8'h00, 8'h00, 1'b1);
        @(posedge clk);
        #1;
        chk("R1 mask kept by clear", ccr_q, 8'hD4);

        // R11: unused code with enable high keeps all flags
        apply(5'd22, 8'h2D, 8'h00, 1'b1);
        apply(5'd25, 8'h00, 8'hFF, 1'b1);
        #1;
        chk("R11 unused result", result, 8'h00);
        @(posedge clk);
        #1;
        chk("R11 unused flags", ccr_q, 8'hED);

        // R1: reset in mid-run returns to 0xD0
        apply(5'd22, 8'h3F, 8'h00, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset mid-run", ccr_q, 8'hD0);
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end
endmodule